// File: doc/BRIEF.md
# Serial Tuning Word Update Sequencer

This block loads a new frequency tuning word into a synthesizer that is programmed over a three-wire serial link. Each transfer is a 16-bit frame shifted out most significant bit first. An active-low frame strobe stays low for the whole frame. A host raises a one-cycle request together with the tuning word, a load-mode bit and a target-register bit. The sequencer then sends a control frame followed by one or two frequency frames. A full load sends the low half and then the high half of the 28-bit word. A low-only load sends just the low half.

The synthesizer applies a new value several of its own clock cycles after the last strobe rises. The exact figure is seven or eight, depending on edge alignment. The host reports each synthesizer clock edge as a one-cycle pulse on `mclk_tick`. After the final frame, the sequencer counts eight such pulses and then raises `freq_live`, which is the latest moment the new frequency can take effect. The sequencer reports busy from the accepted request until `freq_live` rises. Any request made while busy is dropped.

Top module: `tw_update_seq`

## Requirements
- R1: Each frame is 16 serial clock cycles with the frame strobe low throughout. Data is sent MSB first. Data changes only on the rising edge of the serial clock, so it is stable while the serial clock is low and is sampled on the falling edge.
- R2: A full load (`full_load`=1) sends exactly three frames, in the order control, low half, high half.
- R3: A low-only load (`full_load`=0) sends exactly two frames, in the order control, low half.
- R4: The control frame has bits 15:14 = 00, bit 13 = load mode (1 full, 0 low-only), bit 11 = `reg_sel`, and all other bits zero.
- R5: A frequency frame carries the prefix 01 in bits 15:14 when `reg_sel`=0, or 10 when `reg_sel`=1. Bits 13:0 hold tuning bits 13:0 for the low half, or tuning bits 27:14 for the high half.
- R6: The serial clock idles high whenever the strobe is high. The strobe falls at least CLK_DIV system cycles before the first falling serial clock edge of a frame.
- R7: Between two frames of one update, the strobe stays high for at least 2*CLK_DIV system cycles, which is one serial clock period.
- R8: `freq_live` rises in the cycle after the eighth `mclk_tick` that follows the final strobe rise, and not before. `busy` stays high until then and falls together with the rise of `freq_live`.
- R9: A request made while `busy` is high, whether during frames or during the settle count, produces no frames and does not change the update in progress.
- R10: After reset the strobe and serial clock are high and `busy` and `freq_live` are low. An accepted request clears `freq_live` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle update request |
| full_load | input | 1 | 1 = send both halves, 0 = low half only |
| reg_sel | input | 1 | Target frequency register select |
| tuning | input | 28 | Tuning word, latched on acceptance |
| mclk_tick | input | 1 | One-cycle pulse per synthesizer clock edge |
| sclk | output | 1 | Serial clock, idle high |
| sdata | output | 1 | Serial data, MSB first |
| sync_n | output | 1 | Active-low frame strobe |
| busy | output | 1 | Update in progress or settling |
| freq_live | output | 1 | New frequency is in effect |

## Verification
The checker assumes that `mclk_tick` and `req` are synchronous one-cycle pulses on `clk`. It also assumes that `tuning`, `full_load` and `reg_sel` need only be valid in the cycle a request is accepted. The bench drives every input at the falling edge of `clk`. It holds each request for exactly one cycle, and it spaces synthesizer ticks at least one idle cycle apart. The rejected requests it issues mid-frame and mid-settle carry different word, mode and register values, so that any leak into the serial stream would show up in the frames the bench captures.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } seq_state_e;

    localparam logic [1:0] FRM_CTRL = 2'd0;
    localparam logic [1:0] FRM_LO   = 2'd1;
    localparam logic [1:0] FRM_HI   = 2'd2;

endpackage

// File: rtl/tw_frame_build.sv
module tw_frame_build #(
    parameter int FRAME_W = 16,
    localparam int HALF_W = FRAME_W - 2
) (
    input  logic [1:0]          idx,
    input  logic                full,
    input  logic                sel,
    input  logic [2*HALF_W-1:0] word,
    output logic [FRAME_W-1:0]  frame
);
    import tw_pkg::*;

    logic [1:0] prefix;

    always_comb begin
        prefix = sel ? 2'b10 : 2'b01;
        frame  = '0;
        case (idx)
            FRM_CTRL: begin
                frame[FRAME_W-3] = full;
                frame[FRAME_W-5] = sel;
            end
            FRM_LO:  frame = {prefix, word[HALF_W-1:0]};
            default: frame = {prefix, word[2*HALF_W-1:HALF_W]};
        endcase
    end

endmodule

// File: rtl/tw_settle_timer.sv
module tw_settle_timer #(
    parameter int TICKS = 8,
    localparam int TW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic tick,
    output logic armed,
    output logic live
);
    typedef struct packed {
        logic          armed;
        logic          live;
        logic [TW-1:0] cnt;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (clear) begin
            d.live = 1'b0;
        end
        if (start) begin
            d.armed = 1'b1;
            d.live  = 1'b0;
            d.cnt   = '0;
        end else if (q.armed && tick) begin
            if (q.cnt == TW'(TICKS - 1)) begin
                d.armed = 1'b0;
                d.live  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign armed = q.armed;
    assign live  = q.live;

endmodule

// File: rtl/tw_update_seq.sv
module tw_update_seq #(
    parameter int FRAME_W      = 16,
    parameter int CLK_DIV      = 4,
    parameter int SETTLE_TICKS = 8,
    localparam int WORD_W = 2 * (FRAME_W - 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              full_load,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] tuning,
    input  logic              mclk_tick,
    output logic              sclk,
    output logic              sdata,
    output logic              sync_n,
    output logic              busy,
    output logic              freq_live
);
    import tw_pkg::*;

    localparam int CW = $clog2(2 * CLK_DIV + 1);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      bidx;
        logic [1:0]         frm;
        logic               full;
        logic               sel;
        logic [WORD_W-1:0]  word;
        logic [FRAME_W-1:0] sh;
    } regs_t;

    regs_t d, q;

    logic               settle_busy;
    logic               accept;
    logic               done_pulse;
    logic [1:0]         ld_idx;
    logic               ld_full;
    logic               ld_sel;
    logic [WORD_W-1:0]  ld_word;
    logic [FRAME_W-1:0] next_frame;
    logic [1:0]         last_frm;

    assign busy   = (q.st != ST_IDLE) || settle_busy;
    assign accept = req && !busy;

    always_comb begin
        if (q.st == ST_IDLE) begin
            ld_idx  = FRM_CTRL;
            ld_full = full_load;
            ld_sel  = reg_sel;
            ld_word = tuning;
        end else begin
            ld_idx  = q.frm + 2'd1;
            ld_full = q.full;
            ld_sel  = q.sel;
            ld_word = q.word;
        end
    end

    tw_frame_build #(.FRAME_W(FRAME_W)) u_build (
        .idx   (ld_idx),
        .full  (ld_full),
        .sel   (ld_sel),
        .word  (ld_word),
        .frame (next_frame)
    );

    assign last_frm = q.full ? FRM_HI : FRM_LO;

    always_comb begin
        d          = q;
        done_pulse = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st   = ST_LEAD;
                    d.cnt  = '0;
                    d.bidx = '0;
                    d.frm  = FRM_CTRL;
                    d.full = full_load;
                    d.sel  = reg_sel;
                    d.word = tuning;
                    d.sh   = next_frame;
                end
            end
            ST_LEAD: begin
                if (q.cnt == CW'(CLK_DIV - 1)) begin
                    d.st  = ST_LOW;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_LOW: begin
                if (q.cnt == CW'(CLK_DIV - 1)) begin
                    d.st  = ST_HIGH;
                    d.cnt = '0;
                    if (q.bidx != LAST_BIT) begin
                        d.sh = {q.sh[FRAME_W-2:0], 1'b0};
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (q.cnt == CW'(CLK_DIV - 1)) begin
                    d.cnt = '0;
                    if (q.bidx == LAST_BIT) begin
                        if (q.frm == last_frm) begin
                            d.st       = ST_IDLE;
                            d.sh       = '0;
                            done_pulse = 1'b1;
                        end else begin
                            d.st = ST_GAP;
                        end
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                        d.st   = ST_LOW;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == CW'(2 * CLK_DIV - 1)) begin
                    d.st   = ST_LEAD;
                    d.cnt  = '0;
                    d.bidx = '0;
                    d.frm  = q.frm + 2'd1;
                    d.sh   = next_frame;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    tw_settle_timer #(.TICKS(SETTLE_TICKS)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (done_pulse),
        .clear (accept),
        .tick  (mclk_tick),
        .armed (settle_busy),
        .live  (freq_live)
    );

    assign sync_n = !((q.st == ST_LEAD) || (q.st == ST_LOW) || (q.st == ST_HIGH));
    assign sclk   = (q.st != ST_LOW);
    assign sdata  = q.sh[FRAME_W-1];

endmodule

// File: rtl/tw_update_seq_checks.sv
module tw_update_seq_checks (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic sync_n,
    input logic sclk,
    input logic sdata,
    input logic mclk_tick,
    input logic freq_live
);

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> sclk);

    assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> $stable(sdata));

    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sync_n);

    assert_live_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        freq_live |-> !busy);

    assert_live_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freq_live) |-> $past(mclk_tick));

    assert_accept_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> !freq_live);

endmodule

bind tw_update_seq tw_update_seq_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy),
    .sync_n    (sync_n),
    .sclk      (sclk),
    .sdata     (sdata),
    .mclk_tick (mclk_tick),
    .freq_live (freq_live)
);

// File: tb/tb_tw_update_seq.sv
module tb_tw_update_seq;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        full_load = 1'b0;
    logic        reg_sel = 1'b0;
    logic [27:0] tuning = '0;
    logic        mclk_tick = 1'b0;
    logic        sclk, sdata, sync_n, busy, freq_live;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    tw_update_seq #(.FRAME_W(16), .CLK_DIV(DIV), .SETTLE_TICKS(8)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .full_load(full_load),
        .reg_sel(reg_sel), .tuning(tuning), .mclk_tick(mclk_tick),
        .sclk(sclk), .sdata(sdata), .sync_n(sync_n), .busy(busy),
        .freq_live(freq_live)
    );

    // serial line monitor
    logic        mon_en = 1'b0;
    logic [15:0] shreg;
    int          nbits = 0;
    int          nfr = 0;
    logic [15:0] frames [0:7];
    int          fbits  [0:7];
    time         t_rise = 0;
    time         t_fall = 0;
    time         min_gap = 0;
    time         min_lead = 0;
    bit          first_fall = 1'b0;
    int          idle_viol = 0;

    always @(negedge sync_n) if (mon_en) begin
        t_fall = $time;
        first_fall = 1'b1;
        if (sclk !== 1'b1) idle_viol++;
        if (nfr > 0 && (t_fall - t_rise) < min_gap) min_gap = t_fall - t_rise;
    end

    always @(negedge sclk) if (mon_en && sync_n === 1'b0) begin
        if (first_fall) begin
            if (($time - t_fall) < min_lead) min_lead = $time - t_fall;
            first_fall = 1'b0;
        end
        shreg = {shreg[14:0], sdata};
        nbits++;
    end

    always @(posedge sync_n) if (mon_en) begin
        if (nfr < 8) begin
            frames[nfr] = shreg;
            fbits[nfr]  = nbits;
        end
        nfr++;
        nbits = 0;
        t_rise = $time;
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input int idx, input bit f,
                                              input bit s, input logic [27:0] w);
        logic [15:0] r;
        logic [1:0]  p;
        p = s ? 2'b10 : 2'b01;
        r = '0;
        if (idx == 0) begin
            r[13] = f;
            r[11] = s;
        end else if (idx == 1) begin
            r = {p, w[13:0]};
        end else begin
            r = {p, w[27:14]};
        end
        return r;
    endfunction

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    task automatic run_txn(input bit f, input bit s, input logic [27:0] w);
        int n;
        n = f ? 3 : 2;
        nfr = 0;
        nbits = 0;
        min_gap = 1000000;
        min_lead = 1000000;
        idle_viol = 0;
        @(negedge clk);
        req = 1'b1; full_load = f; reg_sel = s; tuning = w;
        @(negedge clk);
        req = 1'b0;
        check(freq_live == 1'b0 && busy == 1'b1, "R10", "live cleared on accept",
              {busy, freq_live}, 2'b10);
        // rejected request mid-frame with different contents (R9)
        repeat (7) @(negedge clk);
        req = 1'b1; full_load = !f; reg_sel = !s; tuning = ~w;
        @(negedge clk);
        req = 1'b0; tuning = '0;
        wait (nfr == n);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            check(fbits[k] == 16, "R1", "bits per frame", fbits[k], 16);
            check(frames[k] == exp_frame(k, f, s, w), f ? "R2" : "R3",
                  "frame content", frames[k], exp_frame(k, f, s, w));
        end
        check(frames[0][13] == f && frames[0][11] == s, "R4", "control frame mode bits",
              frames[0], exp_frame(0, f, s, w));
        check(frames[1] == exp_frame(1, f, s, w), "R5", "low half frame",
              frames[1], exp_frame(1, f, s, w));
        check(idle_viol == 0 && min_lead >= DIV * 10, "R6", "strobe lead / sclk idle",
              min_lead / 10, DIV);
        check(min_gap >= 2 * DIV * 10, "R7", "inter-frame gap cycles",
              min_gap / 10, 2 * DIV);
        for (int k = 1; k <= 8; k++) begin
            if (k == 4) begin
                req = 1'b1; full_load = f; reg_sel = s; tuning = w ^ 28'h1;
                @(negedge clk);
                req = 1'b0;
            end
            mclk_tick = 1'b1;
            @(negedge clk);
            mclk_tick = 1'b0;
            if (k == 7) check(freq_live == 1'b0 && busy == 1'b1, "R8",
                              "not live after 7 ticks", {busy, freq_live}, 2'b10);
            if (k == 8) check(freq_live == 1'b1 && busy == 1'b0, "R8",
                              "live after 8 ticks", {busy, freq_live}, 2'b01);
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
        check(nfr == n && sync_n == 1'b1 && freq_live == 1'b1, "R9",
              "rejected requests sent nothing", nfr, n);
    endtask

    initial begin
        logic [27:0] words [0:5];
        words[0] = 28'h0000000;
        words[1] = 28'hFFFFFFF;
        words[2] = 28'h1234567;
        words[3] = 28'hAAAAAAA;
        words[4] = 28'h0004001;
        words[5] = 28'h8000FFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sync_n == 1'b1 && sclk == 1'b1 && busy == 1'b0 && freq_live == 1'b0,
              "R10", "reset state", {sync_n, sclk, busy, freq_live}, 4'b1100);
        mon_en = 1'b1;
        for (int fi = 0; fi < 2; fi++) begin
            for (int si = 0; si < 2; si++) begin
                for (int wi = 0; wi < 6; wi++) begin
                    run_txn(fi[0], si[0], words[wi]);
                end
            end
        end
        report();
    end

endmodule